// File: doc/BRIEF.md
# Banked Per-Core Interrupt Interface Registers

This block keeps, for every processor core attached to an interrupt controller, the interface control word and two binary-point fields. Register accesses arrive on a simple single-cycle bus that carries a core index, a register offset and a secure/non-secure attribute. A write updates the addressed core's state at the clock edge. A read returns its data in a registered output one cycle later, and that value is held until the next read.

Only one control word is stored per core, and it is the secure-side copy. When the security option is built in, a non-secure access sees a view made by shifting two bits of that word down by one position. A non-secure write is shifted up by one position and merges only into the bits that the non-secure side owns. The binary-point register is banked between the secure and non-secure sides, and each side has its own lower limit. An aliased binary-point offset gives secure software a way to reach the non-secure copy. Two parameters select the variant: the architecture revision (1 or 2) and whether the security option is present. Grouping exists when the revision is 2 or the security option is present.

The block also drives one forwarding-enable output per core. Each output combines the distributor's two group enables with that core's interface group enables.

Top module: `ifc_regs`

## Requirements
- R1: Each core has its own control word and binary-point pair. An access addressed to one core never changes what another core reads back.
- R2: A secure write to offset 0x00, or any write there when the security option is absent, stores the written value ANDed with a variant mask: 0x001 for revision 1, 0x01F for revision 1 with security, 0x21F for revision 2, and 0x61F for revision 2 with security. A read from that side returns the stored word. Bit 0 is the group-0 enable and bit 1 is the group-1 enable.
- R3: With the security option present, a non-secure read of offset 0x00 returns the stored word ANDed with 0x402 and then shifted right by one position.
- R4: With the security option present, a non-secure write to offset 0x00 takes the written value shifted left by one position. It replaces only bit 1 of the stored word, and also bit 10 when the revision is 2. Every other stored bit keeps its value.
- R5: A secure access to offset 0x08, or any access there when the security option is absent, reaches the secure binary point. This is a 3-bit field taken from write-data bits 2:0, with a lower limit of 0.
- R6: With the security option present, a non-secure access to offset 0x08 reaches the non-secure binary point. A written value below 1 is stored as 1.
- R7: Offset 0x1C reads as zero and ignores writes when grouping is absent, and also on a non-secure access when the security option is present. In all other cases it reads and writes the non-secure binary point, with the same lower limit of 1.
- R8: Reset clears every control word, sets every secure binary point to 0, and sets every non-secure binary point to 1.
- R9: Any offset other than 0x00, 0x08 and 0x1C reads as zero, and writes to it have no effect.
- R10: The forwarding enable of a core is high only when at least one distributor group enable is high and at least one of bits 0 and 1 of that core's control word is set.
- R11: Read data appears on the output in the cycle after the access edge. It stays unchanged through any cycle that carries no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accValid | input | 1 | Access present this cycle |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accSecure | input | 1 | Access carries the secure attribute |
| accCore | input | CORE_W | Index of the addressed core |
| accOffset | input | ADDR_W | Register byte offset |
| accWdata | input | DATA_W | Write data |
| distEnGrp0 | input | 1 | Distributor group-0 enable |
| distEnGrp1 | input | 1 | Distributor group-1 enable |
| rdData | output | DATA_W | Registered read data |
| fwdEn | output | NUM_CORES | Per-core forwarding enable |

## Verification
A write takes effect at the access edge, so a read issued in the next cycle already sees the new value. That read's data shows up on rdData one edge later. The bench drives each access on a falling edge and samples rdData on the falling edge that follows the capturing rising edge. The forwarding enables are combinational from stored state and the distributor inputs, so they are checked one falling edge after the write or input change that moves them. Four instances cover the four revision/security variants, so that every control-word mask and the no-grouping case of 0x1C can be compared against a value worked out by hand.

// File: rtl/ifc_regs_pkg.sv
package ifc_regs_pkg;

  // Byte offsets decoded by this block
  localparam int OFS_CTL  = 'h00;
  localparam int OFS_BPR  = 'h08;
  localparam int OFS_ABPR = 'h1C;

  // Control word bit positions
  localparam int CB_GRP0_EN = 0;
  localparam int CB_GRP1_EN = 1;
  localparam int CB_EOI_NS  = 10;

  localparam int BPR_W      = 3;
  localparam int BPR_S_MIN  = 0;
  localparam int BPR_NS_MIN = 1;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_CTL_S,
    RD_CTL_NS,
    RD_BPR_S,
    RD_BPR_NS
  } rdSel_e;

  typedef struct packed {
    logic   ctlWrS;
    logic   ctlWrNs;
    logic   bprWrS;
    logic   bprWrNs;
    logic   rdEn;
    rdSel_e rdSel;
  } strobes_t;

  // Writable control bits for the secure (or only) side
  function automatic logic [31:0] ctlSecMask(input int rev, input bit sec);
    if (rev == 2) return sec ? 32'h61F : 32'h21F;
    return sec ? 32'h01F : 32'h001;
  endfunction

  // Stored bits the non-secure side owns
  function automatic logic [31:0] ctlNsMask(input int rev);
    logic [31:0] m;
    m = 32'(1) << CB_GRP1_EN;
    if (rev == 2) m = m | (32'(1) << CB_EOI_NS);
    return m;
  endfunction

  function automatic logic [BPR_W-1:0] clampBpr(input logic [BPR_W-1:0] v,
                                                input int minVal);
    return (int'(v) < minVal) ? BPR_W'(minVal) : v;
  endfunction

endpackage

// File: rtl/ifc_regs_ctrl.sv
module ifc_regs_ctrl
  import ifc_regs_pkg::*;
#(
  parameter int  ADDR_W     = 8,
  parameter bit  SEC_EXT    = 1'b1,
  parameter bit  HAS_GROUPS = 1'b1
) (
  input  logic              accValid,
  input  logic              accWrite,
  input  logic              accSecure,
  input  logic [ADDR_W-1:0] accOffset,
  output strobes_t          stb
);

  logic nsView;
  logic hitCtl, hitBpr, hitAbpr, abprOpen;
  logic doWr, doRd;

  assign nsView   = SEC_EXT && !accSecure;
  assign hitCtl   = accOffset == ADDR_W'(OFS_CTL);
  assign hitBpr   = accOffset == ADDR_W'(OFS_BPR);
  assign hitAbpr  = accOffset == ADDR_W'(OFS_ABPR);
  assign abprOpen = HAS_GROUPS && !nsView;
  assign doWr     = accValid && accWrite;
  assign doRd     = accValid && !accWrite;

  always_comb begin
    stb         = '0;
    stb.rdSel   = RD_ZERO;
    stb.rdEn    = doRd;
    stb.ctlWrS  = doWr && hitCtl && !nsView;
    stb.ctlWrNs = doWr && hitCtl && nsView;
    stb.bprWrS  = doWr && hitBpr && !nsView;
    stb.bprWrNs = doWr && ((hitBpr && nsView) || (hitAbpr && abprOpen));
    if (hitCtl)                    stb.rdSel = nsView ? RD_CTL_NS : RD_CTL_S;
    else if (hitBpr)               stb.rdSel = nsView ? RD_BPR_NS : RD_BPR_S;
    else if (hitAbpr && abprOpen)  stb.rdSel = RD_BPR_NS;
  end

endmodule

// File: rtl/ifc_regs_dp.sv
module ifc_regs_dp
  import ifc_regs_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int REV       = 2,
  parameter bit SEC_EXT   = 1'b1,
  parameter int CORE_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic [CORE_W-1:0]    accCore,
  input  logic [DATA_W-1:0]    accWdata,
  input  logic                 distEnGrp0,
  input  logic                 distEnGrp1,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_CORES-1:0] fwdEn
);

  localparam logic [DATA_W-1:0] SEC_MASK = DATA_W'(ctlSecMask(REV, SEC_EXT));
  localparam logic [DATA_W-1:0] NS_MASK  = DATA_W'(ctlNsMask(REV));
  localparam logic [DATA_W-1:0] NS_VIEW  = DATA_W'((32'(1) << CB_GRP1_EN) |
                                                   (32'(1) << CB_EOI_NS));

  logic [DATA_W-1:0] ctlView   [NUM_CORES];
  logic [BPR_W-1:0]  bprSView  [NUM_CORES];
  logic [BPR_W-1:0]  bprNsView [NUM_CORES];
  logic              distAny;

  assign distAny = distEnGrp0 | distEnGrp1;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [DATA_W-1:0] ctlQ;
    logic [BPR_W-1:0]  bprSQ, bprNsQ;
    logic              sel;

    assign sel = accCore == CORE_W'(c);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlQ   <= '0;
        bprSQ  <= BPR_W'(BPR_S_MIN);
        bprNsQ <= BPR_W'(BPR_NS_MIN);
      end else if (sel) begin
        if (stb.ctlWrS)
          ctlQ <= accWdata & SEC_MASK;
        else if (stb.ctlWrNs)
          ctlQ <= (ctlQ & ~NS_MASK) | ((accWdata << 1) & NS_MASK);
        if (stb.bprWrS)
          bprSQ <= clampBpr(accWdata[BPR_W-1:0], BPR_S_MIN);
        if (stb.bprWrNs)
          bprNsQ <= clampBpr(accWdata[BPR_W-1:0], BPR_NS_MIN);
      end
    end

    assign ctlView[c]   = ctlQ;
    assign bprSView[c]  = bprSQ;
    assign bprNsView[c] = bprNsQ;
    assign fwdEn[c]     = distAny && (ctlQ[CB_GRP0_EN] || ctlQ[CB_GRP1_EN]);
  end

  logic [DATA_W-1:0] rdNext;

  always_comb begin
    rdNext = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (accCore == CORE_W'(c)) begin
        unique case (stb.rdSel)
          RD_CTL_S:  rdNext = ctlView[c];
          RD_CTL_NS: rdNext = (ctlView[c] & NS_VIEW) >> 1;
          RD_BPR_S:  rdNext = DATA_W'(bprSView[c]);
          RD_BPR_NS: rdNext = DATA_W'(bprNsView[c]);
          default:   rdNext = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (stb.rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/ifc_regs.sv
module ifc_regs
  import ifc_regs_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int REV       = 2,
  parameter bit SEC_EXT   = 1'b1,
  parameter int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic                 accSecure,
  input  logic [CORE_W-1:0]    accCore,
  input  logic [ADDR_W-1:0]    accOffset,
  input  logic [DATA_W-1:0]    accWdata,
  input  logic                 distEnGrp0,
  input  logic                 distEnGrp1,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_CORES-1:0] fwdEn
);

  localparam bit HAS_GROUPS = (REV == 2) || SEC_EXT;

  strobes_t stb;

  ifc_regs_ctrl #(
    .ADDR_W(ADDR_W), .SEC_EXT(SEC_EXT), .HAS_GROUPS(HAS_GROUPS)
  ) u_ctrl (
    .accValid (accValid),
    .accWrite (accWrite),
    .accSecure(accSecure),
    .accOffset(accOffset),
    .stb      (stb)
  );

  ifc_regs_dp #(
    .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .REV(REV),
    .SEC_EXT(SEC_EXT), .CORE_W(CORE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .accCore   (accCore),
    .accWdata  (accWdata),
    .distEnGrp0(distEnGrp0),
    .distEnGrp1(distEnGrp1),
    .rdData    (rdData),
    .fwdEn     (fwdEn)
  );

endmodule

// File: rtl/ifc_regs_check.sv
module ifc_regs_check #(
  parameter int NUM_CORES = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int REV       = 2,
  parameter bit SEC_EXT   = 1'b1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 accValid,
  input logic                 accWrite,
  input logic                 accSecure,
  input logic [ADDR_W-1:0]    accOffset,
  input logic                 distEnGrp0,
  input logic                 distEnGrp1,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_CORES-1:0] fwdEn
);

  localparam bit HAS_GROUPS = (REV == 2) || SEC_EXT;

  logic isRd, nsView, knownOfs;
  assign isRd     = accValid && !accWrite;
  assign nsView   = SEC_EXT && !accSecure;
  assign knownOfs = (accOffset == ADDR_W'('h00)) || (accOffset == ADDR_W'('h08)) ||
                    (accOffset == ADDR_W'('h1C));

  // R10: no distributor enable means no forwarding anywhere
  assert_fwd_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(distEnGrp0 || distEnGrp1) |-> fwdEn == '0);

  // R11: read data only moves on a read
  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !isRd |=> $stable(rdData));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && !knownOfs) |=> rdData == '0);

  assert_alias_closed_R7: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && accOffset == ADDR_W'('h1C) && (!HAS_GROUPS || nsView)) |=> rdData == '0);

  assert_ns_ctl_view_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && nsView && accOffset == ADDR_W'('h00)) |=> (rdData & ~DATA_W'('h201)) == '0);

  assert_bpr_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && accOffset == ADDR_W'('h08)) |=> rdData[DATA_W-1:3] == '0);

  assert_ns_bpr_min_R6: assert property (@(posedge clk) disable iff (!rstN)
    (isRd && nsView && accOffset == ADDR_W'('h08)) |=> rdData != '0);

endmodule

bind ifc_regs ifc_regs_check #(
  .NUM_CORES(NUM_CORES), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .REV(REV), .SEC_EXT(SEC_EXT)
) u_check (
  .clk       (clk),
  .rstN      (rstN),
  .accValid  (accValid),
  .accWrite  (accWrite),
  .accSecure (accSecure),
  .accOffset (accOffset),
  .distEnGrp0(distEnGrp0),
  .distEnGrp1(distEnGrp1),
  .rdData    (rdData),
  .fwdEn     (fwdEn)
);

// File: tb/ifc_regs_test.sv
module ifc_regs_test;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 5000;
  localparam int NV = 30;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accValid = 1'b0, accWrite = 1'b0, accSecure = 1'b1;
  logic [1:0]  accCore = '0;
  logic [7:0]  accOffset = '0;
  logic [31:0] accWdata = '0;
  logic        distEnGrp0 = 1'b0, distEnGrp1 = 1'b0;
  logic [31:0] rdData, rdV1, rdV1S, rdV2;
  logic [3:0]  fwdEn, fwdV1, fwdV1S, fwdV2;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifc_regs #(.REV(2), .SEC_EXT(1'b1)) uut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSecure(accSecure), .accCore(accCore), .accOffset(accOffset),
    .accWdata(accWdata), .distEnGrp0(distEnGrp0), .distEnGrp1(distEnGrp1),
    .rdData(rdData), .fwdEn(fwdEn));
  ifc_regs #(.REV(1), .SEC_EXT(1'b0)) uutV1 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSecure(accSecure), .accCore(accCore), .accOffset(accOffset),
    .accWdata(accWdata), .distEnGrp0(distEnGrp0), .distEnGrp1(distEnGrp1),
    .rdData(rdV1), .fwdEn(fwdV1));
  ifc_regs #(.REV(1), .SEC_EXT(1'b1)) uutV1S (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSecure(accSecure), .accCore(accCore), .accOffset(accOffset),
    .accWdata(accWdata), .distEnGrp0(distEnGrp0), .distEnGrp1(distEnGrp1),
    .rdData(rdV1S), .fwdEn(fwdV1S));
  ifc_regs #(.REV(2), .SEC_EXT(1'b0)) uutV2 (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accSecure(accSecure), .accCore(accCore), .accOffset(accOffset),
    .accWdata(accWdata), .distEnGrp0(distEnGrp0), .distEnGrp1(distEnGrp1),
    .rdData(rdV2), .fwdEn(fwdV2));

  // {write, secure, core, offset, wdata[11:0], expected[11:0]}
  localparam logic [35:0] VEC [NV] = '{
    {1'b0,1'b1,2'd0,8'h00,12'h000,12'h000},  // R8 reset control
    {1'b1,1'b1,2'd0,8'h00,12'hFFF,12'h000},
    {1'b0,1'b1,2'd0,8'h00,12'h000,12'h61F},  // R2
    {1'b0,1'b0,2'd0,8'h00,12'h000,12'h201},  // R3
    {1'b1,1'b0,2'd0,8'h00,12'h000,12'h000},
    {1'b0,1'b1,2'd0,8'h00,12'h000,12'h21D},  // R4 only bits 1,10 cleared
    {1'b1,1'b0,2'd0,8'h00,12'h201,12'h000},
    {1'b0,1'b1,2'd0,8'h00,12'h000,12'h61F},  // R4 restored
    {1'b0,1'b1,2'd1,8'h00,12'h000,12'h000},  // R1 other core untouched
    {1'b1,1'b1,2'd1,8'h08,12'h007,12'h000},
    {1'b0,1'b1,2'd1,8'h08,12'h000,12'h007},  // R5
    {1'b1,1'b0,2'd1,8'h08,12'h000,12'h000},
    {1'b0,1'b0,2'd1,8'h08,12'h000,12'h001},  // R6 clamp to 1
    {1'b0,1'b1,2'd1,8'h1C,12'h000,12'h001},  // R7 alias
    {1'b1,1'b1,2'd1,8'h1C,12'h005,12'h000},
    {1'b0,1'b0,2'd1,8'h08,12'h000,12'h005},  // R7 alias write
    {1'b0,1'b0,2'd1,8'h1C,12'h000,12'h000},  // R7 closed
    {1'b1,1'b0,2'd1,8'h1C,12'h002,12'h000},
    {1'b0,1'b0,2'd1,8'h08,12'h000,12'h005},  // R7 write ignored
    {1'b0,1'b1,2'd1,8'h08,12'h000,12'h007},  // R5 banks separate
    {1'b1,1'b1,2'd2,8'h10,12'hFFF,12'h000},
    {1'b0,1'b1,2'd2,8'h10,12'h000,12'h000},  // R9
    {1'b0,1'b1,2'd2,8'h00,12'h000,12'h000},  // R9 no side effect
    {1'b1,1'b1,2'd2,8'h00,12'h001,12'h000},
    {1'b1,1'b1,2'd2,8'h08,12'h000,12'h000},
    {1'b0,1'b1,2'd2,8'h08,12'h000,12'h000},  // R5 min 0
    {1'b1,1'b0,2'd2,8'h08,12'hFF8,12'h000},
    {1'b0,1'b0,2'd2,8'h08,12'h000,12'h001},  // R6 clamp
    {1'b1,1'b1,2'd2,8'h08,12'hFFD,12'h000},
    {1'b0,1'b1,2'd2,8'h08,12'h000,12'h005}   // R5 low 3 bits
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge after the capture edge
  task automatic acc(input logic wr, input logic sec, input logic [1:0] core,
                     input logic [7:0] ofs, input logic [31:0] wd);
    accValid = 1'b1; accWrite = wr; accSecure = sec;
    accCore = core; accOffset = ofs; accWdata = wd;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  initial begin
    for (int w = 0; w < WDOG_LIMIT; w++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check("R8 rdData reset", rdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [35:0] v;
      v = VEC[i];
      acc(v[35], v[34], v[33:32], v[31:24], {20'h0, v[23:12]});
      if (!v[35]) begin
        case (v[31:24])
          8'h00:   tag = v[34] ? "R2" : "R3";
          8'h08:   tag = v[34] ? "R5" : "R6";
          8'h1C:   tag = "R7";
          default: tag = "R9";
        endcase
        check(tag, rdData, {20'h0, v[11:0]});
      end
    end

    // R11: a write does not disturb held read data
    acc(1'b1, 1'b1, 2'd2, 8'h08, 32'h3);
    check("R11 hold after write", rdData, 32'h5);
    acc(1'b0, 1'b1, 2'd2, 8'h08, 32'h0);
    check("R11 new read", rdData, 32'h3);

    // R2: variant masks on core 3
    acc(1'b1, 1'b1, 2'd3, 8'h00, 32'hFFFF_FFFF);
    acc(1'b0, 1'b1, 2'd3, 8'h00, 32'h0);
    check("R2 v2+sec", rdData, 32'h61F);
    check("R2 v1", rdV1, 32'h001);
    check("R2 v1+sec", rdV1S, 32'h01F);
    check("R2 v2", rdV2, 32'h21F);

    // R4: non-secure write, bit 10 only on revision 2
    acc(1'b1, 1'b0, 2'd3, 8'h00, 32'h0);
    acc(1'b0, 1'b1, 2'd3, 8'h00, 32'h0);
    check("R4 v2+sec", rdData, 32'h21D);
    check("R4 v1+sec", rdV1S, 32'h01D);
    check("R4 v1 plain write", rdV1, 32'h0);
    check("R4 v2 plain write", rdV2, 32'h0);

    // R7: aliased offset per variant (core 3 non-secure bp is 1)
    acc(1'b0, 1'b1, 2'd3, 8'h1C, 32'h0);
    check("R7 v1 no groups", rdV1, 32'h0);
    check("R7 v2 no sec", rdV2, 32'h1);
    check("R7 v1+sec", rdV1S, 32'h1);
    acc(1'b1, 1'b1, 2'd3, 8'h1C, 32'h6);
    acc(1'b0, 1'b1, 2'd3, 8'h08, 32'h0);
    check("R7 v1 write ignored", rdV1, 32'h0);

    // R10: forwarding (ctl: c0=61F c1=0 c2=001 c3=21D)
    distEnGrp0 = 1'b0; distEnGrp1 = 1'b0;
    @(negedge clk);
    check("R10 dist off", {28'h0, fwdEn}, 32'h0);
    distEnGrp1 = 1'b1;
    @(negedge clk);
    check("R10 grp1 only", {28'h0, fwdEn}, 32'hD);
    distEnGrp1 = 1'b0; distEnGrp0 = 1'b1;
    acc(1'b1, 1'b0, 2'd1, 8'h00, 32'h1);
    check("R10 core1 via NS grp1", {28'h0, fwdEn}, 32'hF);

    // R8: reset mid-run with distributor enabled
    rstN = 1'b0;
    @(negedge clk);
    check("R8 fwd cleared", {28'h0, fwdEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    acc(1'b0, 1'b1, 2'd0, 8'h00, 32'h0);
    check("R8 ctl cleared", rdData, 32'h0);
    acc(1'b0, 1'b1, 2'd1, 8'h08, 32'h0);
    check("R8 secure bp", rdData, 32'h0);
    acc(1'b0, 1'b0, 2'd1, 8'h08, 32'h0);
    check("R8 ns bp", rdData, 32'h1);

    summary();
  end

endmodule